// File: doc/BRIEF.md
# Page-Aligned Flash Program Splitter

This block takes one write request for a serial NOR flash (a start address and a byte count) and turns it into a series of page program operations. None of them crosses a page boundary. The write data arrives on a ready/valid byte stream. The block produces a stream of command frames for a byte-level serial link that sits below it. Each frame is a run of bytes ended by a last flag. A frame may also ask the link for one reply byte, which returns on a separate strobe.

For each chunk, the block polls the device status until the busy bit clears, then sends the following frames in order:

1. a write-enable frame,
2. a program frame (opcode, address, data),
3. a write-disable frame.

It then moves the address forward and lowers the remaining count. If the request's last byte lies at or beyond the 16 MiB mark, all program frames carry four address bytes. In that case the whole sequence is wrapped in an enter-wide-address frame and an exit-wide-address frame. The block pulses `done` when the request ends. If the device stays busy too long, it also pulses `err` and sends nothing further.

Top module: `flash_psplit`

## Requirements
- R1: While reset is held and afterwards until a start arrives, `busy`, `done`, `err`, `tx_valid` and `wr_ready` are all low.
- R2: Each program frame carries N data bytes, where N = 256 − (address AND 255), limited to the bytes still remaining. The address then advances by N, so only the first and last chunks can be partial.
- R3: A program frame is byte 0x02 followed by the chunk address, most significant byte first. The address is 3 bytes (bits 23:0), or 4 bytes (bits 31:0) when start + length − 1 ≥ 0x0100_0000. The frame ends with the chunk's last data byte.
- R4: Before every chunk, the block sends a one-byte poll frame 0x05 with `tx_rd` high and waits for `rx_valid`. It repeats the poll while bit 0 of `rx_byte` is 1. The other reply bits have no effect.
- R5: If POLL_LIMIT consecutive replies all have bit 0 set, `done` and `err` pulse together and no further frame is sent.
- R6: Each chunk sits between a one-byte frame 0x06 sent directly before its program frame and a one-byte frame 0x04 sent directly after it.
- R7: When the 4-byte form applies, a one-byte frame 0xB7 is sent once before the first poll, and a one-byte frame 0xE9 is sent once after the last 0x04 frame. Neither is sent otherwise.
- R8: A start with length 0 raises `done` in the cycle after start is sampled and sends no frame.
- R9: `wr_ready` is high only while data bytes are being sent. In that phase each accepted input byte appears unchanged, and in order, as the next `tx_data` byte.
- R10: `busy` is high from the cycle after a nonzero start until the finish. `done` is a single-cycle pulse in the cycle after the final frame's last byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, sampled while idle |
| start_addr | input | ADDR_W | First flash byte address |
| length | input | LEN_W | Number of bytes to write |
| wr_valid | input | 1 | Write data byte available |
| wr_data | input | 8 | Write data byte |
| wr_ready | output | 1 | Write data byte taken this cycle if valid |
| tx_valid | output | 1 | Frame byte available to the link |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Byte ends its frame |
| tx_rd | output | 1 | Frame expects one reply byte |
| tx_ready | input | 1 | Link accepts the frame byte |
| rx_valid | input | 1 | Reply byte strobe |
| rx_byte | input | 8 | Reply byte (status) |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle finish pulse |
| err | output | 1 | Timeout flag, valid with done |

## Verification
The main function is exercised with four kinds of request:
- A page-aligned full page, which needs exactly one chunk.
- An unaligned span over two page boundaries, which forces a short head, a full middle page and a short tail.
- A single byte at the last offset of a page.
- A span that crosses the 16 MiB mark, set against one that ends exactly on the last byte below it.

Together these separate the offset arithmetic from the clipping by remaining count, and the 3-byte address form from the 4-byte form. The busy reply count is varied per run; setting it to one below and equal to the poll limit shows where the timeout starts. Stalls on the link ready line show that frame bytes and pass-through data hold under back-pressure.

// File: rtl/flash_psplit_pkg.sv
// Shared types and frame opcodes for the page program splitter.
// Assumes a byte-level link below that frames bytes by a last flag.
package flash_psplit_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ENTER,
        ST_POLL,
        ST_PWAIT,
        ST_WREN,
        ST_HDR,
        ST_DATA,
        ST_WRDI,
        ST_EXIT,
        ST_DONE
    } seq_state_t;

    localparam logic [7:0] OP_PROG  = 8'h02;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_STAT  = 8'h05;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WIDE  = 8'hB7;
    localparam logic [7:0] OP_NARW  = 8'hE9;

endpackage

// File: rtl/psplit_chunk.sv
// Computes the byte count of the next program chunk: the room left in
// the current page, clipped to the remaining count.
// Assumes PAGE_BYTES is a power of two and LEN_W exceeds its log2.
module psplit_chunk #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 24,
    parameter int PAGE_BYTES = 256
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  remain,
    output logic [LEN_W-1:0]  chunk_len
);
    localparam int OFF_W = $clog2(PAGE_BYTES);

    logic [LEN_W-1:0] room;

    // Room to the end of the page, then clip to what is left.
    always_comb begin
        room      = LEN_W'(PAGE_BYTES) - LEN_W'(addr[OFF_W-1:0]);
        chunk_len = (remain < room) ? remain : room;
    end
endmodule

// File: rtl/psplit_poll_ctr.sv
// Counts busy status replies within one poll sequence and flags the
// reply that would reach the limit.
// Assumes LIMIT is at least 2.
module psplit_poll_ctr #(
    parameter int LIMIT = 4000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic at_limit
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt;

    // Busy reply counter, cleared at the start of each sequence.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt <= '0;
        else if (bump)       cnt <= cnt + 1'b1;
    end

    // The next busy reply is the last one allowed.
    assign at_limit = (cnt == CNT_W'(LIMIT - 1));
endmodule

// File: rtl/flash_psplit.sv
// Splits one flash write request into page-bounded program frames,
// each preceded by a status poll and wrapped in enable/disable frames.
// Assumes the link returns exactly one reply byte per read frame and
// that ADDR_W is 32 so the wide address form carries four bytes.
module flash_psplit
    import flash_psplit_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 24,
    parameter int PAGE_BYTES = 256,
    parameter int POLL_LIMIT = 4000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  length,
    input  logic              wr_valid,
    input  logic [7:0]        wr_data,
    output logic              wr_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic              tx_rd,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic              busy,
    output logic              done,
    output logic              err
);
    localparam int SUM_W    = ADDR_W + 1;
    localparam int WIDE_BIT = 24;

    seq_state_t        state;
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  remain;
    logic [LEN_W-1:0]  chunk_left;
    logic [LEN_W-1:0]  chunk_len;
    logic [2:0]        hdr_idx;
    logic [2:0]        hdr_last;
    logic              wide_q;
    logic              err_q;
    logic              fire;
    logic              poll_clear;
    logic              poll_bump;
    logic              poll_at_limit;
    logic [SUM_W-1:0]  end_addr;
    logic              wide_req;
    logic              in_data;
    logic              in_pwait;

    psplit_chunk #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)
    ) chunk_i (
        .addr(cur_addr), .remain(remain), .chunk_len(chunk_len)
    );

    psplit_poll_ctr #(.LIMIT(POLL_LIMIT)) poll_i (
        .clk(clk), .rst_n(rst_n), .clear(poll_clear),
        .bump(poll_bump), .at_limit(poll_at_limit)
    );

    // Wide form is needed when the request's last byte reaches 16 MiB.
    always_comb begin
        end_addr = {1'b0, start_addr} + SUM_W'(length) - 1'b1;
        wide_req = |end_addr[SUM_W-1:WIDE_BIT];
    end

    assign hdr_last = wide_q ? 3'd4 : 3'd3;
    assign fire     = tx_valid && tx_ready;
    assign in_data  = (state == ST_DATA);
    assign in_pwait = (state == ST_PWAIT);
    assign busy     = (state != ST_IDLE) && (state != ST_DONE);
    assign done     = (state == ST_DONE);
    assign err      = done && err_q;

    // Poll counter control: clear per sequence, bump on busy replies.
    always_comb begin
        poll_clear = (state == ST_IDLE) ||
                     (in_pwait && rx_valid && !rx_byte[0]);
        poll_bump  = in_pwait && rx_valid && rx_byte[0] && !poll_at_limit;
    end

    // Frame byte and handshake outputs for the current state.
    always_comb begin
        tx_valid = 1'b0;
        tx_data  = 8'h00;
        tx_last  = 1'b0;
        tx_rd    = 1'b0;
        wr_ready = 1'b0;
        unique case (state)
            ST_ENTER: begin tx_valid = 1'b1; tx_data = OP_WIDE; tx_last = 1'b1; end
            ST_POLL:  begin tx_valid = 1'b1; tx_data = OP_STAT; tx_last = 1'b1; tx_rd = 1'b1; end
            ST_WREN:  begin tx_valid = 1'b1; tx_data = OP_WREN; tx_last = 1'b1; end
            ST_HDR: begin
                tx_valid = 1'b1;
                if (hdr_idx == 3'd0) tx_data = OP_PROG;
                else tx_data = 8'(cur_addr >> {hdr_last - hdr_idx, 3'b000});
            end
            ST_DATA: begin
                tx_valid = wr_valid;
                tx_data  = wr_data;
                tx_last  = (chunk_left == LEN_W'(1));
                wr_ready = tx_ready;
            end
            ST_WRDI:  begin tx_valid = 1'b1; tx_data = OP_WRDI; tx_last = 1'b1; end
            ST_EXIT:  begin tx_valid = 1'b1; tx_data = OP_NARW; tx_last = 1'b1; end
            default:  begin end
        endcase
    end

    // Sequencer: request capture, per-chunk steps, pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cur_addr   <= '0;
            remain     <= '0;
            chunk_left <= '0;
            hdr_idx    <= '0;
            wide_q     <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    err_q <= 1'b0;
                    if (length == '0) begin
                        state <= ST_DONE;
                    end else begin
                        cur_addr <= start_addr;
                        remain   <= length;
                        wide_q   <= wide_req;
                        state    <= wide_req ? ST_ENTER : ST_POLL;
                    end
                end
                ST_ENTER: if (fire) state <= ST_POLL;
                ST_POLL:  if (fire) state <= ST_PWAIT;
                ST_PWAIT: if (rx_valid) begin
                    if (!rx_byte[0]) state <= ST_WREN;
                    else if (poll_at_limit) begin
                        err_q <= 1'b1;
                        state <= ST_DONE;
                    end else state <= ST_POLL;
                end
                ST_WREN: if (fire) begin
                    hdr_idx    <= '0;
                    chunk_left <= chunk_len;
                    state      <= ST_HDR;
                end
                ST_HDR: if (fire) begin
                    if (hdr_idx == hdr_last) state <= ST_DATA;
                    else hdr_idx <= hdr_idx + 1'b1;
                end
                ST_DATA: if (fire) begin
                    chunk_left <= chunk_left - 1'b1;
                    if (chunk_left == LEN_W'(1)) begin
                        cur_addr <= cur_addr + ADDR_W'(chunk_len);
                        remain   <= remain - chunk_len;
                        state    <= ST_WRDI;
                    end
                end
                ST_WRDI: if (fire) begin
                    if (remain != '0)  state <= ST_POLL;
                    else if (wide_q)   state <= ST_EXIT;
                    else               state <= ST_DONE;
                end
                ST_EXIT: if (fire) state <= ST_DONE;
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/flash_psplit_checker.sv
// Protocol checks for the page program splitter, bound to its top.
// Assumes the link holds tx_ready stable only as given by its driver.
module flash_psplit_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_data,
    input logic       wr_valid,
    input logic       wr_ready,
    input logic [7:0] wr_data,
    input logic       rx_valid,
    input logic [7:0] rx_byte,
    input logic       in_data,
    input logic       in_pwait
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!tx_valid && !wr_ready));

    p_hold_ctl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !in_data) |=> (tx_valid && $stable(tx_data)));

    p_ready_go_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pwait && rx_valid && !rx_byte[0]) |=> (tx_valid && tx_data == 8'h06));

    p_err_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    p_pass_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ready && wr_valid) |-> (tx_valid && tx_data == wr_data));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_start_takes_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done) |=> (busy || done));
endmodule

bind flash_psplit flash_psplit_checker chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .err(err), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .in_data(in_data),
    .in_pwait(in_pwait)
);

// File: tb/flash_psplit_tb_top.sv
`timescale 1ns/100ps
// Scoreboard bench: a driver task queues the expected frame bytes,
// a monitor pops and compares each byte the link accepts.
module flash_psplit_tb_top;
    localparam int LIM = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic [23:0] length = '0;
    logic        wr_valid = 1'b1;
    logic [7:0]  wr_data;
    logic        wr_ready;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_last;
    logic        tx_rd;
    logic        tx_ready = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        busy;
    logic        done;
    logic        err;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int last_hs = -10;
    int data_idx = 0;
    int busy_n = 0;
    int polls_seen = 0;
    int rx_delay = 0;
    bit stall_on = 1'b0;
    logic [10:0] expq[$];

    flash_psplit #(.POLL_LIMIT(LIM)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .length(length), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_last(tx_last), .tx_rd(tx_rd), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .busy(busy), .done(done),
        .err(err)
    );

    always #2.5 clk = ~clk;

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    assign wr_data = pat(data_idx);

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic push(input bit d, input bit l, input bit r, input logic [7:0] b);
        expq.push_back({d, l, r, b});
    endtask

    // Cycle count, data source advance, link stalls and status replies.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (wr_valid && wr_ready) data_idx <= data_idx + 1;
        tx_ready <= stall_on ? ((cyc % 3) != 0) : 1'b1;
        if (tx_valid && tx_ready && tx_last && tx_rd) begin
            polls_seen = polls_seen + 1;
            rx_delay <= 2;
        end else if (rx_delay > 0) rx_delay <= rx_delay - 1;
        rx_valid <= (rx_delay == 1);
        rx_byte  <= (polls_seen <= busy_n) ? 8'h03 : 8'h02;
        if (tx_valid && tx_ready && !wr_ready && tx_last && !tx_rd && tx_data == 8'h06)
            polls_seen = 0;
    end

    // Monitor: compare every accepted frame byte with the queue head.
    always @(negedge clk) begin
        if (rst_n && tx_valid && tx_ready) begin
            logic [10:0] got;
            got = {wr_ready, tx_last, tx_rd, tx_data};
            last_hs = cyc;
            if (expq.size() == 0) chk(1'b0, "R2/R3/R4/R6/R7/R9 extra byte", got, 0);
            else begin
                logic [10:0] want;
                want = expq.pop_front();
                chk(got == want, "R2/R3/R4/R6/R7/R9 stream", got, want);
            end
        end
    end

    // Driver: queue the expected frames, issue the request, await finish.
    task automatic run_req(input longint addr, input int len, input int bn, input bit stall);
        longint a;
        int r;
        int d;
        bit wide;
        bit exp_err;
        exp_err = (bn >= LIM);
        busy_n = bn;
        polls_seen = 0;
        stall_on = stall;
        a = addr; r = len; d = data_idx;
        wide = (len > 0) && ((addr + len - 1) >= 64'h100_0000);
        if (wide) push(0, 1, 0, 8'hB7);
        while (r > 0) begin
            int c;
            int np;
            np = exp_err ? LIM : bn + 1;
            for (int p = 0; p < np; p++) push(0, 1, 1, 8'h05);
            if (exp_err) break;
            push(0, 1, 0, 8'h06);
            c = 256 - int'(a % 256);
            if (c > r) c = r;
            push(0, 0, 0, 8'h02);
            if (wide) push(0, 0, 0, 8'(a >> 24));
            push(0, 0, 0, 8'(a >> 16));
            push(0, 0, 0, 8'(a >> 8));
            push(0, 0, 0, 8'(a));
            for (int k = 0; k < c; k++) push(1, k == c - 1, 0, pat(d + k));
            push(0, 1, 0, 8'h04);
            d += c; a += c; r -= c;
        end
        if (wide && !exp_err) push(0, 1, 0, 8'hE9);
        @(posedge clk); #1;
        start = 1'b1; start_addr = 32'(addr); length = 24'(len);
        @(posedge clk); #1;
        start = 1'b0;
        @(negedge clk);
        if (len == 0) begin
            chk(done == 1'b1, "R8 done next cycle", done, 1);
            chk(err == 1'b0, "R8 no error", err, 0);
        end else begin
            chk(busy == 1'b1, "R10 busy after start", busy, 1);
            for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
            chk(done == 1'b1, "R10 done reached", done, 1);
            chk(err == exp_err, "R5 error flag", err, exp_err);
            if (!exp_err) chk(cyc == last_hs + 1, "R10 done timing", cyc, last_hs + 1);
        end
        chk(expq.size() == 0, "R2/R5/R7/R8 all frames sent", expq.size(), 0);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R10 single done pulse", {done, busy}, 0);
        expq.delete();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 5);
        fails++; checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Test sequence.
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk({busy, done, err, tx_valid, wr_ready} == 5'b0, "R1 reset outputs",
            {busy, done, err, tx_valid, wr_ready}, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({busy, done, tx_valid, wr_ready} == 4'b0, "R1 idle outputs",
            {busy, done, tx_valid, wr_ready}, 0);
        run_req(64'h0, 0, 0, 0);            // R8 empty request
        run_req(64'h100, 256, 0, 0);        // R2 aligned full page
        run_req(64'h1F0, 300, 2, 1);        // R2 R4 unaligned, busy, stalls
        run_req(64'h2FF, 1, 1, 0);          // R2 single byte at page end
        run_req(64'hFFFFF8, 20, 1, 1);      // R3 R7 crosses 16 MiB
        run_req(64'hFFFFF0, 16, 0, 0);      // R3 ends just below 16 MiB
        run_req(64'h400, 10, LIM - 1, 0);   // R5 one below the limit
        run_req(64'h500, 10, LIM, 0);       // R5 timeout
        run_req(64'h80, 4, 0, 0);           // R5 recovery after error
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule